// File: doc/BRIEF.md
# Shift, Rotate and Bit-Field Unit

A purely combinational 32-bit datapath block for an integer execution stage. It provides left and right shifts, logical or arithmetic, and right rotates. The amount for these comes either from a 5-bit immediate or from the low five bits of a second register operand. It also pulls a bit field out of the source, right-aligned. It can merge the low bits of the source into a chosen field of the current destination value. Finally, it can exchange the two bytes inside each 16-bit half of the source.

The operation code selects exactly one function. The result appears on `res_o` in the same cycle. Field placement is given as a start bit and a width-minus-one value. Placements that run past bit 31 raise `fld_bad_o`, and the result is then unpredictable.

Top module: `sbf_unit`

## Requirements
- R1: Operation codes on `op_i` are: 0 left shift by immediate, 1 logical right shift by immediate, 2 arithmetic right shift by immediate, 3 right rotate by immediate, 4 to 7 the same four by register amount, 8 field extract, 9 field insert, 10 byte swap within halfwords. Left and logical right shifts fill vacated bits with zeros.
- R2: Arithmetic right shifts fill vacated bits with bit 31 of the source.
- R3: A right rotate by n places source bits n-1:0 in the top n result bits and source bits 31:n below them.
- R4: Register-amount operations use only `amt_reg_i[4:0]`. Bits 31:5 have no effect on the result.
- R5: A shift or rotate with an amount of zero returns the source unchanged.
- R6: Extract returns source bits pos+size-1:pos in result bits size-1:0 and zeros above, where size = `fsz_m1_i`+1.
- R7: Insert places source bits size-1:0 into result bits pos+size-1:pos and copies every other bit from `dst_i`. A size of 32 at position 0 gives the source unchanged.
- R8: Byte swap returns source bytes 2, 3, 0, 1 (bits 23:16, 31:24, 7:0, 15:8) from most to least significant.
- R9: `fld_bad_o` is 1 exactly when the operation is extract or insert and pos+size exceeds 32. It is 0 for every other operation.
- R10: Operation codes 11 to 15 produce a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation select |
| src_i | input | 32 | Source operand |
| amt_reg_i | input | 32 | Second register operand, low 5 bits used as amount |
| shamt_i | input | 5 | Immediate shift or rotate amount |
| fpos_i | input | 5 | Field start bit |
| fsz_m1_i | input | 5 | Field width minus one |
| dst_i | input | 32 | Current destination value, merged by insert |
| res_o | output | 32 | Result |
| fld_bad_o | output | 1 | Field runs past bit 31 |

## Verification
The assertions assume that every input holds a defined 0/1 value, and that the op code and field fields are settled whenever the result is examined. The field checks apply only when the field fits inside the word; an overlong field is checked only through the flag. The bench drives every input from a single task and samples half a clock period later, so no check sees inputs that are partly updated. The random sweep compares the result only when the placement is valid, and checks the flag in both cases.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned AMT_W  = $clog2(DATA_W);
  localparam int unsigned OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SLL   = 4'd0,
    OP_SRL   = 4'd1,
    OP_SRA   = 4'd2,
    OP_ROTR  = 4'd3,
    OP_SLLV  = 4'd4,
    OP_SRLV  = 4'd5,
    OP_SRAV  = 4'd6,
    OP_ROTRV = 4'd7,
    OP_EXT   = 4'd8,
    OP_INS   = 4'd9,
    OP_SWAP  = 4'd10
  } sbf_op_e;
endpackage

// File: rtl/sbf_shifter.sv
module sbf_shifter #(
  parameter int unsigned W = 32,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [SW-1:0] amt_i,
  input  logic          left_i,
  input  logic          arith_i,
  input  logic          rot_i,
  output logic [W-1:0]  data_o
);
  logic [W-1:0] stage [SW+1];
  logic         sign_fill;

  function automatic logic [W-1:0] bit_rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  assign sign_fill = arith_i & data_i[W-1];
  assign stage[0]  = left_i ? bit_rev(data_i) : data_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int unsigned SH = 1 << k;
    logic [SH-1:0] fill;
    always_comb begin
      if (rot_i) fill = stage[k][SH-1:0];
      else       fill = {SH{sign_fill}};
    end
    assign stage[k+1] = amt_i[k] ? {fill, stage[k][W-1:SH]} : stage[k];
  end

  assign data_o = left_i ? bit_rev(stage[SW]) : stage[SW];
endmodule

// File: rtl/sbf_field.sv
module sbf_field #(
  parameter int unsigned W = 32,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  src_i,
  input  logic [W-1:0]  dst_i,
  input  logic [SW-1:0] pos_i,
  input  logic [SW-1:0] sz_m1_i,
  output logic [W-1:0]  ext_o,
  output logic [W-1:0]  ins_o,
  output logic          over_o
);
  logic [SW:0]   size;
  logic [SW+1:0] span_end;
  logic [W-1:0]  ones;
  logic [W-1:0]  place_mask;

  assign size       = {1'b0, sz_m1_i} + 1'b1;
  assign span_end   = {2'b00, pos_i} + {1'b0, size};
  assign over_o     = span_end > (SW+2)'(W);
  assign ones       = {W{1'b1}} >> ((SW+1)'(W) - size);
  assign place_mask = ones << pos_i;
  assign ext_o      = (src_i >> pos_i) & ones;
  assign ins_o      = (dst_i & ~place_mask) | ((src_i & ones) << pos_i);
endmodule

// File: rtl/sbf_swap.sv
module sbf_swap #(
  parameter int unsigned W = 32,
  localparam int unsigned HALVES = W / 16
) (
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o
);
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign data_o[16*h+15:16*h] = {data_i[16*h+7:16*h], data_i[16*h+15:16*h+8]};
  end
endmodule

// File: rtl/sbf_unit.sv
module sbf_unit
  import sbf_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] amt_reg_i,
  input  logic [AMT_W-1:0]  shamt_i,
  input  logic [AMT_W-1:0]  fpos_i,
  input  logic [AMT_W-1:0]  fsz_m1_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] res_o,
  output logic              fld_bad_o
);
  sbf_op_e              op;
  logic [AMT_W-1:0]     amt;
  logic                 is_shift, left, arith, rot, field_op;
  logic [DATA_W-1:0]    sh_res, ext_res, ins_res, swap_res;
  logic                 over;
  logic [DATA_W-AMT_W-1:0] unused_amt_hi;

  assign op            = sbf_op_e'(op_i);
  assign unused_amt_hi = amt_reg_i[DATA_W-1:AMT_W];
  assign is_shift      = (op_i < 4'd8);
  assign amt           = op_i[2] ? amt_reg_i[AMT_W-1:0] : shamt_i;
  assign left          = (op_i[1:0] == 2'd0);
  assign arith         = (op_i[1:0] == 2'd2);
  assign rot           = (op_i[1:0] == 2'd3);
  assign field_op      = (op == OP_EXT) || (op == OP_INS);

  sbf_shifter #(.W(DATA_W)) i_shifter (
    .data_i (src_i), .amt_i (amt), .left_i (left),
    .arith_i(arith), .rot_i (rot), .data_o (sh_res)
  );

  sbf_field #(.W(DATA_W)) i_field (
    .src_i (src_i), .dst_i (dst_i), .pos_i (fpos_i), .sz_m1_i(fsz_m1_i),
    .ext_o (ext_res), .ins_o (ins_res), .over_o (over)
  );

  sbf_swap #(.W(DATA_W)) i_swap (.data_i(src_i), .data_o(swap_res));

  always_comb begin
    if (is_shift) res_o = sh_res;
    else begin
      unique case (op)
        OP_EXT:  res_o = ext_res;
        OP_INS:  res_o = ins_res;
        OP_SWAP: res_o = swap_res;
        default: res_o = '0;
      endcase
    end
  end

  assign fld_bad_o = field_op & over;
endmodule

// File: rtl/sbf_unit_chk.sv
module sbf_unit_chk
  import sbf_pkg::*;
(
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] src_i,
  input logic [DATA_W-1:0] amt_reg_i,
  input logic [AMT_W-1:0]  shamt_i,
  input logic [AMT_W-1:0]  fpos_i,
  input logic [AMT_W-1:0]  fsz_m1_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [DATA_W-1:0] res_o,
  input logic              fld_bad_o
);
  logic [AMT_W-1:0] eff_amt;
  logic [AMT_W+1:0] fend;
  logic [AMT_W:0]   fsize;
  logic [DATA_W-1:0] fmask;
  logic [DATA_W-AMT_W-1:0] unused_hi;

  assign unused_hi = amt_reg_i[DATA_W-1:AMT_W];
  assign eff_amt   = op_i[2] ? amt_reg_i[AMT_W-1:0] : shamt_i;
  assign fsize     = {1'b0, fsz_m1_i} + 1'b1;
  assign fend      = {2'b00, fpos_i} + {1'b0, fsize};

  always_comb begin
    fmask = '0;
    for (int i = 0; i < DATA_W; i++)
      if (i >= int'(fpos_i) && i < int'(fend)) fmask[i] = 1'b1;
  end

  always_comb begin
    if (op_i < 4'd8 && eff_amt == '0)
      AST_ZERO_AMT_PASS: assert (res_o == src_i) else $error("zero amount altered source"); // R5
    if (op_i == 4'd2 || op_i == 4'd6)
      AST_SRA_KEEPS_SIGN: assert (res_o[DATA_W-1] == src_i[DATA_W-1]) else $error("sign lost"); // R2
    if (op_i == 4'd3 || op_i == 4'd7)
      AST_ROT_KEEPS_ONES: assert ($countones(res_o) == $countones(src_i)) else $error("rotate lost bits"); // R3
    if (op_i == 4'd10)
      AST_SWAP_KEEPS_ONES: assert ($countones(res_o) == $countones(src_i)) else $error("swap lost bits"); // R8
    if (op_i == 4'd8 && !fld_bad_o)
      AST_EXT_ZERO_ABOVE: assert ((res_o >> fsize) == '0) else $error("extract not zero filled"); // R6
    if (op_i == 4'd9 && !fld_bad_o)
      AST_INS_KEEPS_OUTSIDE: assert (((res_o ^ dst_i) & ~fmask) == '0) else $error("insert touched outside"); // R7
    if (op_i != 4'd8 && op_i != 4'd9)
      AST_FLAG_FIELD_ONLY: assert (!fld_bad_o) else $error("flag on non-field op"); // R9
    if (op_i > 4'd10)
      AST_RESERVED_ZERO: assert (res_o == '0) else $error("reserved op nonzero"); // R10
  end
endmodule

bind sbf_unit sbf_unit_chk i_sbf_unit_chk (
  .op_i(op_i), .src_i(src_i), .amt_reg_i(amt_reg_i), .shamt_i(shamt_i),
  .fpos_i(fpos_i), .fsz_m1_i(fsz_m1_i), .dst_i(dst_i),
  .res_o(res_o), .fld_bad_o(fld_bad_o)
);

// File: tb/test_sbf_unit.sv
module test_sbf_unit;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 15;
  localparam int  NRAND = 400;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] src;
    logic [31:0] amt;
    logic [4:0]  sh;
    logic [4:0]  pos;
    logic [4:0]  szm1;
    logic [31:0] dst;
    logic [31:0] exp;
    logic        bad;
    logic        chk_res;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'd0,  32'h87654321, 32'h0,        5'd4,  5'd0,  5'd0,  32'h0,        32'h76543210, 1'b0, 1'b1, 8'd1},
    '{4'd1,  32'h87654321, 32'h0,        5'd8,  5'd0,  5'd0,  32'h0,        32'h00876543, 1'b0, 1'b1, 8'd1},
    '{4'd2,  32'h87654321, 32'h0,        5'd8,  5'd0,  5'd0,  32'h0,        32'hFF876543, 1'b0, 1'b1, 8'd2},
    '{4'd3,  32'h87654321, 32'h0,        5'd8,  5'd0,  5'd0,  32'h0,        32'h21876543, 1'b0, 1'b1, 8'd3},
    '{4'd4,  32'h87654321, 32'hFFFFFFE4, 5'd0,  5'd0,  5'd0,  32'h0,        32'h76543210, 1'b0, 1'b1, 8'd4},
    '{4'd6,  32'h87654321, 32'h00000020, 5'd7,  5'd0,  5'd0,  32'h0,        32'h87654321, 1'b0, 1'b1, 8'd5},
    '{4'd7,  32'h87654321, 32'h0000003F, 5'd0,  5'd0,  5'd0,  32'h0,        32'h0ECA8643, 1'b0, 1'b1, 8'd3},
    '{4'd8,  32'h87654321, 32'h0,        5'd0,  5'd8,  5'd7,  32'hFFFFFFFF, 32'h00000043, 1'b0, 1'b1, 8'd6},
    '{4'd8,  32'h87654321, 32'h0,        5'd0,  5'd28, 5'd3,  32'h0,        32'h00000008, 1'b0, 1'b1, 8'd6},
    '{4'd9,  32'hFFFFFFAB, 32'h0,        5'd0,  5'd4,  5'd7,  32'h12345678, 32'h12345AB8, 1'b0, 1'b1, 8'd7},
    '{4'd9,  32'hCAFEF00D, 32'h0,        5'd0,  5'd0,  5'd31, 32'h12345678, 32'hCAFEF00D, 1'b0, 1'b1, 8'd7},
    '{4'd10, 32'h87654321, 32'h0,        5'd0,  5'd0,  5'd0,  32'h0,        32'h65872143, 1'b0, 1'b1, 8'd8},
    '{4'd8,  32'h87654321, 32'h0,        5'd0,  5'd30, 5'd3,  32'h0,        32'h0,        1'b1, 1'b0, 8'd9},
    '{4'd1,  32'h87654321, 32'h0,        5'd31, 5'd30, 5'd31, 32'h0,        32'h00000001, 1'b0, 1'b1, 8'd9},
    '{4'd15, 32'h87654321, 32'h0,        5'd3,  5'd0,  5'd0,  32'hFFFFFFFF, 32'h0,        1'b0, 1'b1, 8'd10}
  };

  logic clk;
  logic [3:0]  op;
  logic [31:0] src, amt_reg, dst, res;
  logic [4:0]  shamt, fpos, fszm1;
  logic        bad;
  int n_chk, n_fail;
  bit done;

  sbf_unit i_sbf_unit (
    .op_i(op), .src_i(src), .amt_reg_i(amt_reg), .shamt_i(shamt),
    .fpos_i(fpos), .fsz_m1_i(fszm1), .dst_i(dst), .res_o(res), .fld_bad_o(bad)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] s,
      input logic [31:0] a, input logic [4:0] sh, input logic [4:0] p,
      input logic [4:0] zm1, input logic [31:0] d);
    logic [31:0] r;
    int n, sz;
    r  = '0;
    n  = (o >= 4 && o <= 7) ? int'(a[4:0]) : int'(sh);
    sz = int'(zm1) + 1;
    for (int i = 0; i < 32; i++) begin
      case (o)
        4'd0, 4'd4: r[i] = (i >= n) ? s[i-n] : 1'b0;
        4'd1, 4'd5: r[i] = (i + n < 32) ? s[i+n] : 1'b0;
        4'd2, 4'd6: r[i] = (i + n < 32) ? s[i+n] : s[31];
        4'd3, 4'd7: r[i] = s[(i+n)%32];
        4'd8:       r[i] = (i < sz && i + int'(p) < 32) ? s[i+int'(p)] : 1'b0;
        4'd9:       r[i] = (i >= int'(p) && i < int'(p) + sz) ? s[i-int'(p)] : d[i];
        4'd10:      r[i] = s[(i/16)*16 + ((i%16)+8)%16];
        default:    r[i] = 1'b0;
      endcase
    end
    return r;
  endfunction

  task automatic apply(input logic [3:0] o, input logic [31:0] s, input logic [31:0] a,
      input logic [4:0] sh, input logic [4:0] p, input logic [4:0] zm1, input logic [31:0] d);
    @(posedge clk);
    op = o; src = s; amt_reg = a; shamt = sh; fpos = p; fszm1 = zm1; dst = d;
    @(negedge clk);
  endtask

  task automatic check_res(input int req, input logic [31:0] exp);
    n_chk++;
    if (res !== exp) begin
      n_fail++;
      $display("FAIL R%0d op=%0d result actual=%h expected=%h", req, op, res, exp);
    end
  endtask

  task automatic check_bad(input int req, input logic exp);
    n_chk++;
    if (bad !== exp) begin
      n_fail++;
      $display("FAIL R%0d op=%0d flag actual=%b expected=%b", req, op, bad, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL R0 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    op = '0; src = '0; amt_reg = '0; shamt = '0; fpos = '0; fszm1 = '0; dst = '0;
    // reset-like idle state: all-zero inputs give a zero result, no flag (R1, R9)
    @(negedge clk);
    check_res(1, 32'h0);
    check_bad(9, 1'b0);

    for (int v = 0; v < NVEC; v++) begin
      apply(VECS[v].op, VECS[v].src, VECS[v].amt, VECS[v].sh, VECS[v].pos, VECS[v].szm1, VECS[v].dst);
      if (VECS[v].chk_res) check_res(int'(VECS[v].req), VECS[v].exp);
      check_bad(9, VECS[v].bad);
    end

    // R4: upper amount bits ignored across all register-amount ops
    for (int o = 4; o < 8; o++) begin
      apply(4'(o), 32'hA5C3_0F96, 32'h5A5A_5A4B, 5'd0, 5'd0, 5'd0, 32'h0);
      check_res(4, model(4'(o), 32'hA5C3_0F96, 32'h0000_000B, 5'd0, 5'd0, 5'd0, 32'h0));
    end
    // R5: zero immediate amount on every immediate op
    for (int o = 0; o < 4; o++) begin
      apply(4'(o), 32'hF00D_BEEF, 32'hFFFF_FFFF, 5'd0, 5'd0, 5'd0, 32'h0);
      check_res(5, 32'hF00D_BEEF);
    end
    // R9: flag is not raised for non-field ops even with an overlong field
    apply(4'd10, 32'h1234_5678, 32'h0, 5'd0, 5'd31, 5'd31, 32'h0);
    check_bad(9, 1'b0);
    check_res(8, 32'h3412_7856);
    // R9 boundary on insert: pos 1 size 32 overflows by one
    apply(4'd9, 32'h0, 32'h0, 5'd0, 5'd1, 5'd31, 32'h0);
    check_bad(9, 1'b1);
    // R6 full-width extract
    apply(4'd8, 32'hDEAD_BEEF, 32'h0, 5'd0, 5'd0, 5'd31, 32'h0);
    check_res(6, 32'hDEAD_BEEF);

    // random sweep against the bench model (R1 R2 R3 R6 R7 R8 R10)
    for (int k = 0; k < NRAND; k++) begin
      logic [3:0] o;
      logic [31:0] s, a, d;
      logic [4:0] sh, p, zm1;
      logic expbad;
      o = 4'($urandom_range(0, 15)); s = $urandom; a = $urandom; d = $urandom;
      sh = 5'($urandom); p = 5'($urandom); zm1 = 5'($urandom);
      expbad = (o == 4'd8 || o == 4'd9) && (int'(p) + int'(zm1) + 1 > 32);
      apply(o, s, a, sh, p, zm1, d);
      check_bad(9, expbad);
      if (!expbad) check_res(int'(o) < 8 ? 1 : (o == 8 ? 6 : (o == 9 ? 7 : (o == 10 ? 8 : 10))),
                             model(o, s, a, sh, p, zm1, d));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule